// File: doc/BRIEF.md
# Atomic Sequence and Reservation Monitor

This block sits between a core's request port and its cache controller and polices the two kinds of atomic access a core may issue. For load-linked / store-conditional pairs it keeps a single reservation made of a valid bit, a line address and an owner ID. A completed load-linked sets the reservation. A store-conditional is judged when it issues: it passes only if the reservation is valid, names the same line and belongs to the same requester.

For read-modify-write sequences it counts atomic reads and atomic writes. Each read must be matched by a write. Both counts clear automatically once they are equal. If an ordinary access arrives while reads are pending and no write has been seen yet, the sequence is abandoned. Any other imbalance raises a protocol-error pulse.

Each issued request is also translated for the controller into a request class and a privilege bit. Completion events are turned into set and clear commands for the per-line atomic mark. All verdicts are combinational in the issue or completion cycle, and the state updates at the next clock edge.

Top module: `atomic_seq_monitor`

## Requirements
- R1: Synchronous active-high reset empties the reservation and zeroes both counts. After reset a store-conditional fails, and an ordinary access raises neither reset_atomics nor proto_err.
- R2: A completion of kind 3 (load-linked) sets the reservation to its done_line, with done_id as the owner.
- R3: A store-conditional issue (kind 4) whose line and ID match a valid reservation has sc_fail=0 and is forwarded. The reservation is then cleared, so a repeat store-conditional fails.
- R4: A store-conditional issue with no reservation, a different line or a different owner asserts sc_fail in the same cycle and has fwd_valid=0.
- R5: An atomic read issue (kind 5) with a write count of zero increments the read count and is forwarded with class 3.
- R6: An atomic write issue (kind 6) is legal when the read count is nonzero and the write count is below it. It increments the write count, and both counts clear when they become equal.
- R7: An ordinary issue (kinds 0 load, 1 store, 2 fetch) while reads are pending and the write count is zero pulses reset_atomics and clears both counts.
- R8: An ordinary issue while the write count is nonzero pulses proto_err and leaves both counts unchanged.
- R9: An atomic read while the write count is nonzero or the read count is at its maximum, and an atomic write with no pending read, each pulse proto_err and change no count. The request is still forwarded.
- R10: A completion of kind 5 pulses mark_set, and one of kind 6 pulses mark_clr. In both cases mark_line equals done_line.
- R11: fwd_class is 0 for load, 1 for store, 2 for fetch and 3 for kinds 3 to 6. fwd_priv is 1 only for mode 1 (supervisor); modes 0 (user), 2 (device) and 3 give 0. Kind 7 is never forwarded and has no effect.
- R12: When a load-linked completion and a store-conditional issue fall in the same cycle, the store-conditional is judged on the reservation held before that cycle, and the completion's set wins the next state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | A request issues this cycle |
| issue_kind | input | 3 | Request kind code |
| issue_line | input | LINE_W | Line address of the issuing request |
| issue_id | input | ID_W | Requester ID |
| issue_mode | input | 2 | Access mode |
| done_valid | input | 1 | A request completes this cycle |
| done_kind | input | 3 | Kind of the completing request |
| done_line | input | LINE_W | Line of the completing request |
| done_id | input | ID_W | Requester ID of the completion |
| sc_fail | output | 1 | Store-conditional rejected at issue |
| fwd_valid | output | 1 | Request is passed to the controller |
| fwd_class | output | 2 | Controller request class |
| fwd_priv | output | 1 | Supervisor privilege for the controller |
| reset_atomics | output | 1 | Abandon pending atomic sequence |
| proto_err | output | 1 | Atomic ordering violation |
| mark_set | output | 1 | Set atomic mark on mark_line |
| mark_clr | output | 1 | Clear atomic mark on mark_line |
| mark_line | output | LINE_W | Line for the mark command |

## Verification
A load-linked completion and a store-conditional issue can land in the same cycle. Their relative priority decides both the verdict and the next reservation. The bench provokes this in two ways: once with an empty reservation on the same line, where the store-conditional must fail and a follow-up store-conditional must pass, and once with a held reservation while the completion targets another line, where the store-conditional must pass and the new line must then be owned by the completing ID. Atomic read and write completions are also applied in the same cycle as atomic issues. This shows that the mark commands and the count updates do not disturb one another.

// File: rtl/asm_pkg.sv
package asm_pkg;

    typedef enum logic [2:0] {
        K_LOAD   = 3'd0,
        K_STORE  = 3'd1,
        K_FETCH  = 3'd2,
        K_LL     = 3'd3,
        K_SC     = 3'd4,
        K_RMW_RD = 3'd5,
        K_RMW_WR = 3'd6,
        K_RSVD   = 3'd7
    } req_kind_e;

    typedef enum logic [1:0] {
        M_USER = 2'd0,
        M_SUPV = 2'd1,
        M_DEV  = 2'd2,
        M_RSVD = 2'd3
    } acc_mode_e;

    typedef enum logic [1:0] {
        C_LOAD   = 2'd0,
        C_STORE  = 2'd1,
        C_FETCH  = 2'd2,
        C_ATOMIC = 2'd3
    } fwd_class_e;

    function automatic logic is_plain(req_kind_e k);
        return (k == K_LOAD) || (k == K_STORE) || (k == K_FETCH);
    endfunction

    function automatic logic is_atomic(req_kind_e k);
        return (k == K_LL) || (k == K_SC) || (k == K_RMW_RD) || (k == K_RMW_WR);
    endfunction

endpackage

// File: rtl/asm_resv_unit.sv
module asm_resv_unit #(
    parameter int LINE_W = 8,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sc_chk,
    input  logic [LINE_W-1:0] chk_line,
    input  logic [ID_W-1:0]   chk_id,
    input  logic              ll_done,
    input  logic [LINE_W-1:0] set_line,
    input  logic [ID_W-1:0]   set_id,
    output logic              sc_fail
);
    logic              rv_q;
    logic [LINE_W-1:0] line_q;
    logic [ID_W-1:0]   own_q;
    logic              hit;

    assign hit     = rv_q && (line_q == chk_line) && (own_q == chk_id);
    assign sc_fail = sc_chk && !hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            rv_q   <= 1'b0;
            line_q <= '0;
            own_q  <= '0;
        end else if (ll_done) begin
            rv_q   <= 1'b1;
            line_q <= set_line;
            own_q  <= set_id;
        end else if (sc_chk && hit) begin
            rv_q   <= 1'b0;
        end
    end

    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> !rv_q);

    assert_ll_sets_R2: assert property (@(posedge clk) disable iff (rst)
        ll_done |=> (rv_q && line_q == $past(set_line) && own_q == $past(set_id)));

    assert_sc_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (sc_chk && !sc_fail && !ll_done) |=> !rv_q);

endmodule

// File: rtl/asm_rmw_balance.sv
module asm_rmw_balance
    import asm_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      iss_v,
    input  req_kind_e iss_kind,
    output logic      rst_atom,
    output logic      proto_err
);
    logic [CNT_W-1:0] rd_q, wr_q, rd_d, wr_d;
    logic             rd_max;

    assign rd_max = (rd_q == {CNT_W{1'b1}});

    always_comb begin
        rd_d      = rd_q;
        wr_d      = wr_q;
        rst_atom  = 1'b0;
        proto_err = 1'b0;
        if (iss_v) begin
            case (iss_kind)
                K_RMW_RD: begin
                    if (wr_q != '0 || rd_max) proto_err = 1'b1;
                    else                      rd_d = rd_q + 1'b1;
                end
                K_RMW_WR: begin
                    if (rd_q == '0 || wr_q >= rd_q) begin
                        proto_err = 1'b1;
                    end else if (wr_q + 1'b1 == rd_q) begin
                        rd_d = '0;
                        wr_d = '0;
                    end else begin
                        wr_d = wr_q + 1'b1;
                    end
                end
                K_LOAD, K_STORE, K_FETCH: begin
                    if (rd_q != '0 && wr_q == '0) begin
                        rst_atom = 1'b1;
                        rd_d     = '0;
                        wr_d     = '0;
                    end else if (wr_q != '0) begin
                        proto_err = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
            wr_q <= '0;
        end else begin
            rd_q <= rd_d;
            wr_q <= wr_d;
        end
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (rd_q == '0 && wr_q == '0));

    assert_wr_le_rd_R6: assert property (@(posedge clk) disable iff (rst)
        wr_q <= rd_q);

    assert_abandon_clears_R7: assert property (@(posedge clk) disable iff (rst)
        rst_atom |=> (rd_q == '0 && wr_q == '0));

    assert_err_keeps_counts_R8: assert property (@(posedge clk) disable iff (rst)
        (iss_v && is_plain(iss_kind) && proto_err) |=> ($stable(rd_q) && $stable(wr_q)));

endmodule

// File: rtl/asm_class_map.sv
module asm_class_map
    import asm_pkg::*;
(
    input  req_kind_e  kind,
    input  acc_mode_e  mode,
    output fwd_class_e cls,
    output logic       priv,
    output logic       fwd_ok
);
    always_comb begin
        case (kind)
            K_LOAD:  cls = C_LOAD;
            K_STORE: cls = C_STORE;
            K_FETCH: cls = C_FETCH;
            default: cls = is_atomic(kind) ? C_ATOMIC : C_LOAD;
        endcase
    end

    assign priv   = (mode == M_SUPV);
    assign fwd_ok = (kind != K_RSVD);

endmodule

// File: rtl/atomic_seq_monitor.sv
module atomic_seq_monitor
    import asm_pkg::*;
#(
    parameter int LINE_W = 8,
    parameter int ID_W   = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [2:0]        issue_kind,
    input  logic [LINE_W-1:0] issue_line,
    input  logic [ID_W-1:0]   issue_id,
    input  logic [1:0]        issue_mode,
    input  logic              done_valid,
    input  logic [2:0]        done_kind,
    input  logic [LINE_W-1:0] done_line,
    input  logic [ID_W-1:0]   done_id,
    output logic              sc_fail,
    output logic              fwd_valid,
    output logic [1:0]        fwd_class,
    output logic              fwd_priv,
    output logic              reset_atomics,
    output logic              proto_err,
    output logic              mark_set,
    output logic              mark_clr,
    output logic [LINE_W-1:0] mark_line
);
    req_kind_e  ikind, dkind;
    fwd_class_e cls;
    logic       fwd_ok;
    logic       sc_chk, ll_done;

    assign ikind   = req_kind_e'(issue_kind);
    assign dkind   = req_kind_e'(done_kind);
    assign sc_chk  = issue_valid && (ikind == K_SC);
    assign ll_done = done_valid && (dkind == K_LL);

    asm_resv_unit #(.LINE_W(LINE_W), .ID_W(ID_W)) u_resv (
        .clk      (clk),
        .rst      (rst),
        .sc_chk   (sc_chk),
        .chk_line (issue_line),
        .chk_id   (issue_id),
        .ll_done  (ll_done),
        .set_line (done_line),
        .set_id   (done_id),
        .sc_fail  (sc_fail)
    );

    asm_rmw_balance #(.CNT_W(CNT_W)) u_bal (
        .clk       (clk),
        .rst       (rst),
        .iss_v     (issue_valid),
        .iss_kind  (ikind),
        .rst_atom  (reset_atomics),
        .proto_err (proto_err)
    );

    asm_class_map u_map (
        .kind   (ikind),
        .mode   (acc_mode_e'(issue_mode)),
        .cls    (cls),
        .priv   (fwd_priv),
        .fwd_ok (fwd_ok)
    );

    assign fwd_class = cls;
    assign fwd_valid = issue_valid && fwd_ok && !sc_fail;
    assign mark_set  = done_valid && (dkind == K_RMW_RD);
    assign mark_clr  = done_valid && (dkind == K_RMW_WR);
    assign mark_line = done_line;

    assert_mark_excl_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mark_set, mark_clr}));

    assert_fail_only_sc_R4: assert property (@(posedge clk) disable iff (rst)
        sc_fail |-> (issue_valid && issue_kind == 3'd4));

    assert_atomic_class_R11: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && issue_kind >= 3'd3) |-> (fwd_class == 2'd3));

endmodule

// File: tb/atomic_seq_monitor_test.sv
module atomic_seq_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 22;

    typedef struct packed {
        logic       iv;
        logic [2:0] ik;
        logic [7:0] il;
        logic [3:0] iid;
        logic [1:0] im;
        logic       dv;
        logic [2:0] dk;
        logic [7:0] dl;
        logic [3:0] did;
        logic       e_fail;
        logic       e_fwd;
        logic [1:0] e_cls;
        logic       e_priv;
        logic       e_rst;
        logic       e_err;
        logic       e_set;
        logic       e_clr;
    } vec_t;

    // iv ik il iid im | dv dk dl did | fail fwd cls priv rst err set clr
    localparam vec_t TBL [NROWS] = '{
        '{1,4,10,1,0, 0,0,0,0,  1,0,3,0,0,0,0,0},  // 0  R1 R4: no reservation after reset
        '{1,0, 5,0,0, 0,0,0,0,  0,1,0,0,0,0,0,0},  // 1  R1 R11: plain load, counts zero
        '{0,0, 0,0,0, 1,3,10,2, 0,0,0,0,0,0,0,0},  // 2  R2: LL done line 10 owner 2
        '{1,4,10,1,0, 0,0,0,0,  1,0,3,0,0,0,0,0},  // 3  R4: wrong owner
        '{1,4,11,2,0, 0,0,0,0,  1,0,3,0,0,0,0,0},  // 4  R4: wrong line
        '{1,4,10,2,1, 0,0,0,0,  0,1,3,1,0,0,0,0},  // 5  R3 R11: match, supervisor
        '{1,4,10,2,0, 0,0,0,0,  1,0,3,0,0,0,0,0},  // 6  R3: cleared after success
        '{1,5,20,0,2, 0,0,0,0,  0,1,3,0,0,0,0,0},  // 7  R5 R11: device -> user
        '{1,5,21,0,0, 1,5,20,0, 0,1,3,0,0,0,1,0},  // 8  R5 R10: mark set
        '{1,1,30,0,1, 0,0,0,0,  0,1,1,1,1,0,0,0},  // 9  R7: abandon
        '{1,2,31,0,3, 0,0,0,0,  0,1,2,0,0,0,0,0},  // 10 R7 R11: counts cleared
        '{1,6,20,0,0, 0,0,0,0,  0,1,3,0,0,1,0,0},  // 11 R9: write with no read
        '{1,5,40,0,0, 0,0,0,0,  0,1,3,0,0,0,0,0},  // 12 R5
        '{1,5,41,0,0, 0,0,0,0,  0,1,3,0,0,0,0,0},  // 13 R5
        '{1,6,40,0,0, 0,0,0,0,  0,1,3,0,0,0,0,0},  // 14 R6: wr=1 rd=2
        '{1,0,50,0,0, 0,0,0,0,  0,1,0,0,0,1,0,0},  // 15 R8
        '{1,5,42,0,0, 0,0,0,0,  0,1,3,0,0,1,0,0},  // 16 R9: read while wr!=0
        '{1,6,41,0,0, 1,6,40,0, 0,1,3,0,0,0,0,1},  // 17 R6 R10: balanced, mark clear
        '{1,0,51,0,0, 0,0,0,0,  0,1,0,0,0,0,0,0},  // 18 R6: counts back to zero
        '{1,4,60,3,0, 1,3,60,3, 1,0,3,0,0,0,0,0},  // 19 R12: judged on old state
        '{1,4,60,3,0, 0,0,0,0,  0,1,3,0,0,0,0,0},  // 20 R12: set took effect
        '{1,7, 0,0,0, 0,0,0,0,  0,0,0,0,0,0,0,0}   // 21 R11: reserved kind
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       issue_valid, done_valid;
    logic [2:0] issue_kind, done_kind;
    logic [7:0] issue_line, done_line;
    logic [3:0] issue_id, done_id;
    logic [1:0] issue_mode;
    logic       sc_fail, fwd_valid, fwd_priv, reset_atomics, proto_err;
    logic       mark_set, mark_clr;
    logic [1:0] fwd_class;
    logic [7:0] mark_line;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atomic_seq_monitor uut (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_kind(issue_kind), .issue_line(issue_line),
        .issue_id(issue_id), .issue_mode(issue_mode),
        .done_valid(done_valid), .done_kind(done_kind), .done_line(done_line), .done_id(done_id),
        .sc_fail(sc_fail), .fwd_valid(fwd_valid), .fwd_class(fwd_class), .fwd_priv(fwd_priv),
        .reset_atomics(reset_atomics), .proto_err(proto_err),
        .mark_set(mark_set), .mark_clr(mark_clr), .mark_line(mark_line)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic iv, input logic [2:0] ik, input logic [7:0] il,
                         input logic [3:0] iid, input logic [1:0] im,
                         input logic dv, input logic [2:0] dk, input logic [7:0] dl,
                         input logic [3:0] did);
        @(negedge clk);
        issue_valid = iv; issue_kind = ik; issue_line = il; issue_id = iid; issue_mode = im;
        done_valid = dv; done_kind = dk; done_line = dl; done_id = did;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        issue_valid = 0; issue_kind = 0; issue_line = 0; issue_id = 0; issue_mode = 0;
        done_valid = 0; done_kind = 0; done_line = 0; done_id = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        rst = 1'b1;
        do_reset();

        // Table walk
        for (int r = 0; r < NROWS; r++) begin
            string tag;
            tag = $sformatf("row%0d", r);
            drive(TBL[r].iv, TBL[r].ik, TBL[r].il, TBL[r].iid, TBL[r].im,
                  TBL[r].dv, TBL[r].dk, TBL[r].dl, TBL[r].did);
            chk(tag, "sc_fail", sc_fail, TBL[r].e_fail);
            chk(tag, "fwd_valid", fwd_valid, TBL[r].e_fwd);
            chk(tag, "fwd_class", fwd_class, TBL[r].e_cls);
            chk(tag, "fwd_priv", fwd_priv, TBL[r].e_priv);
            chk(tag, "reset_atomics", reset_atomics, TBL[r].e_rst);
            chk(tag, "proto_err", proto_err, TBL[r].e_err);
            chk(tag, "mark_set", mark_set, TBL[r].e_set);
            chk(tag, "mark_clr", mark_clr, TBL[r].e_clr);
            if (TBL[r].dv)
                chk(tag, "mark_line R10", mark_line, TBL[r].dl);
        end

        // R1: reset drops a held reservation and pending reads
        do_reset();
        drive(0, 0, 0, 0, 0, 1, 3, 7, 5);
        drive(1, 5, 9, 0, 0, 0, 0, 0, 0);
        do_reset();
        drive(1, 4, 7, 5, 0, 0, 0, 0, 0);
        chk("R1", "sc_fail after reset", sc_fail, 1);
        drive(1, 0, 9, 0, 0, 0, 0, 0, 0);
        chk("R1", "reset_atomics after reset", reset_atomics, 0);

        // R9: read count saturates at 15 with CNT_W=4
        do_reset();
        for (int i = 0; i < 15; i++) begin
            drive(1, 5, 8'(i), 0, 0, 0, 0, 0, 0);
            chk("R5", "proto_err while filling", proto_err, 0);
        end
        drive(1, 5, 99, 0, 0, 0, 0, 0, 0);
        chk("R9", "proto_err at read max", proto_err, 1);
        chk("R9", "fwd_valid at read max", fwd_valid, 1);
        drive(1, 0, 1, 0, 0, 0, 0, 0, 0);
        chk("R9", "count kept, plain abandons", reset_atomics, 1);

        // R12: held reservation, SC passes while LL done for another line wins
        do_reset();
        drive(0, 0, 0, 0, 0, 1, 3, 7, 5);
        drive(1, 4, 7, 5, 0, 1, 3, 8, 6);
        chk("R12", "sc_fail with held reservation", sc_fail, 0);
        chk("R12", "fwd_valid", fwd_valid, 1);
        drive(1, 4, 8, 6, 0, 0, 0, 0, 0);
        chk("R12", "new owner holds line 8", sc_fail, 0);
        drive(1, 4, 8, 6, 0, 0, 0, 0, 0);
        chk("R3", "second SC fails", sc_fail, 1);
        idle();

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule